// File: doc/BRIEF.md
# Asynchronous Host Register Write Port

This block is the register front end of a small framebuffer video controller. A slow host processor drives an 8-bit data bus, a 3-bit register index and an active-low write strobe. These signals have no timing relationship to the video clock, and the host may toggle them at any rate without waiting for a reply. The port never drives the bus: data flows only from the host into the block.

Inside the video clock domain, the strobe passes through a two-flop synchronizer. A falling edge of the synchronized strobe starts a settling wait of one full clock cycle. Only after that wait are the index and data lines captured. The captured write then updates one of the following:

- the X coordinate, 9 bits, loaded as a low byte plus a separate high bit;
- the Y coordinate;
- the vertical scroll offset;
- the control bits.

The block can also turn a write into a pixel store. A write to the pixel-data register emits a one-cycle framebuffer write request. Its linear address is Y*320 + X. When the auto-advance control bit is set, X steps forward after each such store and returns to 0 past column 319. This lets a host stream a row of pixels without reloading X. The register contents are presented continuously to the scan-out logic.

Top module: `host_reg_port`

## Requirements
- R1: After reset, X, Y, scroll, the mode bit and the auto-advance bit all read 0, and no write request is issued.
- R2: Register index 0 loads X[7:0] from the data byte and index 1 loads X[8] from data bit 0, each leaving the other X bits unchanged. Index 2 loads Y.
- R3: The index and data lines are captured on the clock edge one full cycle after the synchronized falling edge of the strobe is detected, and not earlier. Bus values that change before that edge do not reach the registers.
- R4: Each low pulse of the strobe performs exactly one register write, however long the strobe stays low.
- R5: A write to index 3 produces exactly one single-cycle request on `px_we_o`. The request carries `px_addr_o` = Y*320 + X, using the X and Y in force before the write, and `px_data_o` = the data byte.
- R6: When auto-advance is set, X increases by 1 after each index-3 write. When it is clear, X is unchanged by index-3 writes.
- R7: An auto-advance from X = 319 (or any larger value) sets X to 0 and leaves Y unchanged.
- R8: Index 4 loads the scroll offset. A written value v of 240 or more is stored as v - 240, so the scroll output is always below 240.
- R9: Index 5 loads the control bits: data bit 0 is the mode bit (`hires_o`) and data bit 1 is auto-advance (`autoinc_o`).
- R10: Writes to indexes 6 and 7 change no output and issue no request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Video clock |
| rst_n | input | 1 | Active-low reset, synchronous to clk |
| host_wr_n | input | 1 | Host write strobe, active low, asynchronous |
| host_idx | input | 3 | Register index from host |
| host_data | input | 8 | Data byte from host |
| x_o | output | 9 | Current X coordinate |
| y_o | output | 8 | Current Y coordinate |
| scroll_o | output | 8 | Vertical scroll offset, always below 240 |
| hires_o | output | 1 | Mode control bit |
| autoinc_o | output | 1 | Auto-advance control bit |
| px_we_o | output | 1 | One-cycle framebuffer write request |
| px_addr_o | output | 17 | Linear pixel address of the request |
| px_data_o | output | 8 | Pixel byte of the request |

## Verification
The bench sweeps all 256 scroll values. A design that skipped the reduction, or reduced it wrongly, would put a scroll of 240 or more on the output. It streams 322 pixel writes along one row with auto-advance on. This catches a wrong address product, a wrap that happens one column early or late, and a wrap that also bumps Y.

It also presents a garbage data byte that changes to the real value only just before the settled capture edge. A port that sampled at the detection edge would store the garbage. It holds one strobe low for thirty cycles, where a level-sensitive port would emit a burst of requests. Finally it writes to the unused indexes, where a port that aliased them onto real registers would change an output.

// File: rtl/hrp_pkg.sv
package hrp_pkg;

  localparam int unsigned BUS_W   = 8;
  localparam int unsigned IDX_W   = 3;
  localparam int unsigned X_W     = 9;
  localparam int unsigned Y_W     = 8;
  localparam int unsigned ROW_LEN = 320;
  localparam int unsigned ROWS    = 240;
  localparam int unsigned PA_W    = 17;

  typedef enum logic [IDX_W-1:0] {
    IDX_XLO  = 3'd0,
    IDX_XHI  = 3'd1,
    IDX_Y    = 3'd2,
    IDX_PIX  = 3'd3,
    IDX_SCRL = 3'd4,
    IDX_CTRL = 3'd5
  } reg_idx_e;

  // Linear framebuffer address of a pixel.
  function automatic logic [PA_W-1:0] pix_addr(input logic [X_W-1:0] x,
                                               input logic [Y_W-1:0] y);
    logic [PA_W-1:0] row_base;
    row_base = PA_W'(y) * PA_W'(ROW_LEN);
    return row_base + PA_W'(x);
  endfunction

  // Column after an auto-advance, returning to zero at the row end.
  function automatic logic [X_W-1:0] x_step(input logic [X_W-1:0] x);
    if (x >= X_W'(ROW_LEN - 1)) return '0;
    return x + X_W'(1);
  endfunction

  // Scroll offset folded into the visible line range.
  function automatic logic [Y_W-1:0] scroll_fold(input logic [Y_W-1:0] v);
    if (v >= Y_W'(ROWS)) return v - Y_W'(ROWS);
    return v;
  endfunction

endpackage

// File: rtl/hrp_strobe_sync.sv
module hrp_strobe_sync #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n_async,
  output logic fall_o,
  output logic busy_o,
  output logic sample_o
);

  localparam int unsigned CNT_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   busy_q;
  logic [CNT_W-1:0]       cnt_q;
  logic                   strobe_s;

  assign strobe_s = sync_q[SYNC_STAGES-1];

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= wr_n_async;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '1;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], wr_n_async};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= strobe_s;
  end

  assign fall_o   = prev_q & ~strobe_s;
  assign sample_o = busy_q && (cnt_q == '0);
  assign busy_o   = busy_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (sample_o) begin
      busy_q <= 1'b0;
    end else if (busy_q) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end else if (fall_o) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(SETTLE_CYC - 1);
    end
  end

endmodule

// File: rtl/hrp_regfile.sv
module hrp_regfile
  import hrp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [BUS_W-1:0] data_i,
  output logic [X_W-1:0]   x_o,
  output logic [Y_W-1:0]   y_o,
  output logic [Y_W-1:0]   scroll_o,
  output logic             hires_o,
  output logic             autoinc_o,
  output logic             pix_evt_o
);

  logic [X_W-1:0] x_q;
  logic [Y_W-1:0] y_q;
  logic [Y_W-1:0] scroll_q;
  logic           hires_q;
  logic           autoinc_q;

  assign pix_evt_o = sample_i && (idx_i == IDX_PIX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q       <= '0;
      y_q       <= '0;
      scroll_q  <= '0;
      hires_q   <= 1'b0;
      autoinc_q <= 1'b0;
    end else if (sample_i) begin
      case (idx_i)
        IDX_XLO:  x_q[7:0]  <= data_i;
        IDX_XHI:  x_q[8]    <= data_i[0];
        IDX_Y:    y_q       <= data_i;
        IDX_PIX:  if (autoinc_q) x_q <= x_step(x_q);
        IDX_SCRL: scroll_q  <= scroll_fold(data_i);
        IDX_CTRL: begin
          hires_q   <= data_i[0];
          autoinc_q <= data_i[1];
        end
        default: ;
      endcase
    end
  end

  assign x_o       = x_q;
  assign y_o       = y_q;
  assign scroll_o  = scroll_q;
  assign hires_o   = hires_q;
  assign autoinc_o = autoinc_q;

endmodule

// File: rtl/hrp_pix_req.sv
module hrp_pix_req
  import hrp_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pix_evt_i,
  input  logic [X_W-1:0]   x_i,
  input  logic [Y_W-1:0]   y_i,
  input  logic [BUS_W-1:0] data_i,
  output logic             we_o,
  output logic [PA_W-1:0]  addr_o,
  output logic [BUS_W-1:0] data_o
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else begin
      we_o <= pix_evt_i;
      if (pix_evt_i) begin
        addr_o <= pix_addr(x_i, y_i);
        data_o <= data_i;
      end
    end
  end

endmodule

// File: rtl/host_reg_port.sv
module host_reg_port
  import hrp_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SETTLE_CYC  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             host_wr_n,
  input  logic [IDX_W-1:0] host_idx,
  input  logic [BUS_W-1:0] host_data,
  output logic [X_W-1:0]   x_o,
  output logic [Y_W-1:0]   y_o,
  output logic [Y_W-1:0]   scroll_o,
  output logic             hires_o,
  output logic             autoinc_o,
  output logic             px_we_o,
  output logic [PA_W-1:0]  px_addr_o,
  output logic [BUS_W-1:0] px_data_o
);

  logic fall_evt;
  logic settle_busy;
  logic sample_evt;
  logic pix_evt;

  hrp_strobe_sync #(
    .SYNC_STAGES (SYNC_STAGES),
    .SETTLE_CYC  (SETTLE_CYC)
  ) u_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_n_async (host_wr_n),
    .fall_o     (fall_evt),
    .busy_o     (settle_busy),
    .sample_o   (sample_evt)
  );

  hrp_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sample_i  (sample_evt),
    .idx_i     (host_idx),
    .data_i    (host_data),
    .x_o       (x_o),
    .y_o       (y_o),
    .scroll_o  (scroll_o),
    .hires_o   (hires_o),
    .autoinc_o (autoinc_o),
    .pix_evt_o (pix_evt)
  );

  hrp_pix_req u_req (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_evt_i (pix_evt),
    .x_i       (x_o),
    .y_i       (y_o),
    .data_i    (host_data),
    .we_o      (px_we_o),
    .addr_o    (px_addr_o),
    .data_o    (px_data_o)
  );

endmodule

// File: rtl/host_reg_port_chk.sv
module host_reg_port_chk
  import hrp_pkg::*;
(
  input logic           clk,
  input logic           rst_n,
  input logic           fall_evt,
  input logic           sample_evt,
  input logic           pix_evt,
  input logic           autoinc_o,
  input logic [X_W-1:0] x_o,
  input logic [Y_W-1:0] y_o,
  input logic [Y_W-1:0] scroll_o,
  input logic           px_we_o
);

  AST_NO_EARLY_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_evt |-> !sample_evt); // R3

  AST_ONE_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
    sample_evt |=> !sample_evt); // R4

  AST_Y_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_evt |=> $stable(y_o)); // R2

  AST_REQ_FROM_PIX: assert property (@(posedge clk) disable iff (!rst_n)
    px_we_o |-> $past(pix_evt)); // R5

  AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    px_we_o |=> !px_we_o); // R5

  AST_X_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_evt && autoinc_o && x_o >= X_W'(ROW_LEN - 1)) |=> (x_o == '0) && $stable(y_o)); // R7

  AST_SCROLL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    scroll_o < Y_W'(ROWS)); // R8

endmodule

bind host_reg_port host_reg_port_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .fall_evt   (fall_evt),
  .sample_evt (sample_evt),
  .pix_evt    (pix_evt),
  .autoinc_o  (autoinc_o),
  .x_o        (x_o),
  .y_o        (y_o),
  .scroll_o   (scroll_o),
  .px_we_o    (px_we_o)
);

// File: tb/host_reg_port_tb.sv
module host_reg_port_tb;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_wr_n = 1'b1;
  logic [2:0]  host_idx = '0;
  logic [7:0]  host_data = '0;
  logic [8:0]  x_o;
  logic [7:0]  y_o;
  logic [7:0]  scroll_o;
  logic        hires_o;
  logic        autoinc_o;
  logic        px_we_o;
  logic [16:0] px_addr_o;
  logic [7:0]  px_data_o;

  int n_checks = 0;
  int n_fails  = 0;
  int req_cnt  = 0;
  int last_addr = 0;
  int last_data = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  host_reg_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .host_wr_n (host_wr_n),
    .host_idx  (host_idx),
    .host_data (host_data),
    .x_o       (x_o),
    .y_o       (y_o),
    .scroll_o  (scroll_o),
    .hires_o   (hires_o),
    .autoinc_o (autoinc_o),
    .px_we_o   (px_we_o),
    .px_addr_o (px_addr_o),
    .px_data_o (px_data_o)
  );

  always @(negedge clk) begin
    if (rst_n && px_we_o) begin
      req_cnt   <= req_cnt + 1;
      last_addr <= int'(px_addr_o);
      last_data <= int'(px_data_o);
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic host_write(input int idx, input int dat, input int low_cyc);
    @(negedge clk);
    host_idx  = 3'(idx);
    host_data = 8'(dat);
    host_wr_n = 1'b0;
    repeat (low_cyc) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  task automatic set_x(input int v);
    host_write(0, v & 8'hff, 5);
    host_write(1, (v >> 8) & 1, 5);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    int ex_x;
    int base;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R1 reset state
    check(x_o == 0, "R1 x", int'(x_o), 0);
    check(y_o == 0, "R1 y", int'(y_o), 0);
    check(scroll_o == 0, "R1 scroll", int'(scroll_o), 0);
    check(hires_o == 0 && autoinc_o == 0, "R1 ctrl", int'({autoinc_o, hires_o}), 0);
    check(px_we_o == 0 && req_cnt == 0, "R1 req", req_cnt, 0);

    // R2 X and Y loads
    for (int v = 0; v < 320; v += 7) begin
      set_x(v);
      check(x_o == 9'(v), "R2 x", int'(x_o), v);
    end
    set_x(300);
    host_write(0, 5, 5);
    check(x_o == 9'(261), "R2 x low keeps bit8", int'(x_o), 261);
    host_write(1, 8'hfe, 5);
    check(x_o == 9'(5), "R2 x bit8 from data bit0", int'(x_o), 5);
    for (int v = 0; v < 256; v += 13) begin
      host_write(2, v, 5);
      check(y_o == 8'(v), "R2 y", int'(y_o), v);
    end

    // R3 settle: garbage before the capture edge, real value after
    host_write(2, 0, 5);
    @(negedge clk);
    host_idx  = 3'd2;
    host_data = 8'haa;
    host_wr_n = 1'b0;
    repeat (3) @(negedge clk);
    check(y_o == 0, "R3 not yet captured", int'(y_o), 0);
    host_data = 8'h37;
    repeat (3) @(negedge clk);
    host_wr_n = 1'b1;
    repeat (6) @(negedge clk);
    check(y_o == 8'h37, "R3 settled capture", int'(y_o), 'h37);

    // R8 scroll, all values
    for (int v = 0; v < 256; v++) begin
      host_write(4, v, 4);
      check(int'(scroll_o) == ((v >= 240) ? v - 240 : v), "R8 scroll",
            int'(scroll_o), (v >= 240) ? v - 240 : v);
    end

    // R9 control bits
    for (int v = 0; v < 4; v++) begin
      host_write(5, v | 8'hf0, 5);
      check(hires_o == v[0] && autoinc_o == v[1], "R9 ctrl",
            int'({autoinc_o, hires_o}), v);
    end

    // R5 R6 R7 auto-advance row sweep
    host_write(5, 2, 5);
    host_write(2, 17, 5);
    set_x(0);
    ex_x = 0;
    for (int i = 0; i < 322; i++) begin
      base = req_cnt;
      host_write(3, (i * 3) & 255, 5);
      check(req_cnt == base + 1, "R5 one request", req_cnt - base, 1);
      check(last_addr == 17 * 320 + ex_x, "R5 address", last_addr, 17 * 320 + ex_x);
      check(last_data == ((i * 3) & 255), "R5 data", last_data, (i * 3) & 255);
      ex_x = (ex_x >= 319) ? 0 : ex_x + 1;
      check(int'(x_o) == ex_x, "R6 R7 x advance", int'(x_o), ex_x);
      check(y_o == 8'd17, "R7 y unchanged", int'(y_o), 17);
    end

    // R7 wrap from a value above the row end
    set_x(400);
    host_write(3, 1, 5);
    check(x_o == 0, "R7 wrap from large x", int'(x_o), 0);

    // R6 auto-advance off
    host_write(5, 0, 5);
    set_x(123);
    host_write(2, 239, 5);
    for (int i = 0; i < 2; i++) begin
      host_write(3, 9, 5);
      check(x_o == 9'd123, "R6 x held", int'(x_o), 123);
      check(last_addr == 239 * 320 + 123, "R5 address no advance", last_addr, 239 * 320 + 123);
    end

    // R4 long strobe
    base = req_cnt;
    host_write(3, 77, 30);
    check(req_cnt == base + 1, "R4 single write", req_cnt - base, 1);

    // R10 unused indexes
    host_write(5, 3, 5);
    base = req_cnt;
    for (int idx = 6; idx < 8; idx++) begin
      for (int d = 0; d < 256; d += 51) begin
        host_write(idx, d, 5);
        check(x_o == 9'd123 && y_o == 8'd239 && scroll_o == 8'd15 &&
              hires_o && autoinc_o, "R10 no change", int'(x_o), 123);
      end
    end
    check(req_cnt == base, "R10 no request", req_cnt - base, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

endmodule